// File: doc/BRIEF.md
# Split-Bus Read Data Collector

This block gathers read data for a processor core from a 64-bit data bus that arrives as two 32-bit halves, a high word and a low word. Each half has its own input-enable output, so the system around the core can run either a shared bidirectional bus or separate unidirectional paths. A transaction is either a single-beat uncached read or a four-beat cache-line burst.

A request is a one-cycle strobe with a burst flag, and the block takes it only when it is idle. From then on the block raises both input enables and samples the two halves on each cycle in which the transfer acknowledge is high. When the final beat has been taken, the block pulses a done strobe. It presents the most recent 64-bit beat and the assembled 256-bit line. A byte-lane selector picks one byte out of the most recent beat, using big-endian lane numbering across the two halves.

Top module: `split_rd_collector`

## Requirements
- R1: A request (`req_valid_i`) is accepted only while the block is idle. A request raised during a transaction has no effect on the beat count, the enables or the captured data.
- R2: A request with `req_burst_i`=0 completes after exactly one acknowledged beat. A request with `req_burst_i`=1 completes after exactly four acknowledged beats.
- R3: Data is captured only in a cycle where `ack_i`=1 and the enables are high. Bus data in any other cycle, including an `ack_i` while idle, leaves the outputs unchanged.
- R4: `ien_hi_o` and `ien_lo_o` are both high from the cycle after acceptance through the cycle of the final acknowledge. Both are low in the cycle that follows it.
- R5: `done_o` is high for exactly one cycle, the cycle after the final acknowledged beat.
- R6: In a burst, beat k (k = 0 for the first acknowledged beat) appears on `line_o[255-64k -: 64]`. This is valid while `done_o` is high.
- R7: `word_o` equals `{data_hi_i, data_lo_i}` from the most recent captured beat. It changes in the cycle after that acknowledge and holds until the next capture.
- R8: `lane_byte_o` is lane `lane_sel_i` of `word_o`. Lane 0 is `word_o[63:56]` (the top byte of the high half), lane 3 is `word_o[39:32]`, lane 4 is `word_o[31:24]`, and lane 7 is `word_o[7:0]`. This output is combinational from `lane_sel_i`.
- R9: While `rst_ni` is low, the block is idle, both enables and `done_o` are low, and `word_o` and `line_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Read request strobe |
| req_burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| ack_i | input | 1 | Transfer acknowledge |
| data_hi_i | input | 32 | High half of read data (lanes 0-3) |
| data_lo_i | input | 32 | Low half of read data (lanes 4-7) |
| lane_sel_i | input | 3 | Byte lane select, 0 to 7 |
| ien_hi_o | output | 1 | Input enable for the high half |
| ien_lo_o | output | 1 | Input enable for the low half |
| done_o | output | 1 | Transaction complete pulse |
| word_o | output | 64 | Most recent captured beat |
| line_o | output | 256 | Assembled burst line |
| lane_byte_o | output | 8 | Selected byte of the most recent beat |

## Verification
The bench puts acknowledges in gaps within a burst, and it sends acknowledges while the block is idle. A design that captured without an enable, or that counted idle acknowledges, would change `word_o` or end a burst early. It raises requests in the middle of a transaction and on the cycle of `done_o`. A design that accepted the first would restart the count, and one that refused the second would lose a transaction. Every lane is swept against a reference byte order, so a mapping with the halves swapped or little-endian lanes shows up as a byte mismatch. The line is compared slot by slot, so reversed beat order in the line fails as well.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } rdc_state_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/rdc_beat_ctrl.sv
module rdc_beat_ctrl
  import rdc_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_burst_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic             cap_en_o,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic             done_o
);
  rdc_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] tgt_q, tgt_d;
  logic             done_q;
  logic             last_beat;

  assign busy_o    = (state_q == ST_COLLECT);
  assign cap_en_o  = busy_o && ack_i;
  assign cap_idx_o = cnt_q;
  assign last_beat = cap_en_o && (cnt_q == tgt_q);
  assign done_o    = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          state_d = ST_COLLECT;
          cnt_d   = '0;
          tgt_d   = req_burst_i ? IDX_W'(BURST_LEN - 1) : '0;
        end
      end
      ST_COLLECT: begin
        if (last_beat) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (cap_en_o) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
      done_q  <= last_beat;
    end
  end
endmodule

// File: rtl/rdc_line_store.sv
module rdc_line_store #(
  parameter int unsigned HALF_W    = 32,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BEAT_W = 2 * HALF_W,
  localparam int unsigned LINE_W = BURST_LEN * BEAT_W,
  localparam int unsigned IDX_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic [IDX_W-1:0]  cap_idx_i,
  input  logic [HALF_W-1:0] hi_i,
  input  logic [HALF_W-1:0] lo_i,
  output logic [BEAT_W-1:0] word_o,
  output logic [LINE_W-1:0] line_o
);
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] word_q;

  assign beat   = {hi_i, lo_i};
  assign word_o = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_q <= '0;
    else if (cap_en_i) word_q <= beat;
  end

  // slot 0 (first beat) sits at the top of the line
  for (genvar g = 0; g < BURST_LEN; g++) begin : g_slot
    logic [BEAT_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q <= '0;
      else if (cap_en_i && (cap_idx_i == IDX_W'(g))) slot_q <= beat;
    end
    assign line_o[LINE_W-1-g*BEAT_W -: BEAT_W] = slot_q;
  end
endmodule

// File: rtl/rdc_lane_mux.sv
module rdc_lane_mux
  import rdc_pkg::*;
#(
  parameter int unsigned BEAT_W = 64,
  localparam int unsigned LANES  = BEAT_W / LANE_W,
  localparam int unsigned SEL_W  = $clog2(LANES)
) (
  input  logic [BEAT_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [LANE_W-1:0] byte_o
);
  logic [LANE_W-1:0] lane_arr [LANES];

  // big-endian lanes: lane 0 is the most significant byte
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_arr[l] = word_i[BEAT_W-1-l*LANE_W -: LANE_W];
  end

  assign byte_o = lane_arr[sel_i];
endmodule

// File: rtl/split_rd_collector.sv
module split_rd_collector #(
  parameter int unsigned HALF_W    = 32,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BEAT_W = 2 * HALF_W,
  localparam int unsigned LINE_W = BURST_LEN * BEAT_W,
  localparam int unsigned SEL_W  = $clog2(BEAT_W / 8),
  localparam int unsigned IDX_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_burst_i,
  input  logic              ack_i,
  input  logic [HALF_W-1:0] data_hi_i,
  input  logic [HALF_W-1:0] data_lo_i,
  input  logic [SEL_W-1:0]  lane_sel_i,
  output logic              ien_hi_o,
  output logic              ien_lo_o,
  output logic              done_o,
  output logic [BEAT_W-1:0] word_o,
  output logic [LINE_W-1:0] line_o,
  output logic [7:0]        lane_byte_o
);
  logic             busy;
  logic             cap_en;
  logic [IDX_W-1:0] cap_idx;

  rdc_beat_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_burst_i (req_burst_i),
    .ack_i       (ack_i),
    .busy_o      (busy),
    .cap_en_o    (cap_en),
    .cap_idx_o   (cap_idx),
    .done_o      (done_o)
  );

  rdc_line_store #(.HALF_W(HALF_W), .BURST_LEN(BURST_LEN)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_i  (cap_en),
    .cap_idx_i (cap_idx),
    .hi_i      (data_hi_i),
    .lo_i      (data_lo_i),
    .word_o    (word_o),
    .line_o    (line_o)
  );

  rdc_lane_mux #(.BEAT_W(BEAT_W)) u_lane (
    .word_i (word_o),
    .sel_i  (lane_sel_i),
    .byte_o (lane_byte_o)
  );

  assign ien_hi_o = busy;
  assign ien_lo_o = busy;
endmodule

// File: rtl/split_rd_collector_chk.sv
module split_rd_collector_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        ack_i,
  input logic        ien_hi_o,
  input logic        ien_lo_o,
  input logic        done_o,
  input logic [63:0] word_o
);
  logic [3:0] acks_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   acks_seen <= '0;
    else if (done_o)               acks_seen <= (ack_i && ien_hi_o) ? 4'd1 : 4'd0;
    else if (ack_i && ien_hi_o)    acks_seen <= acks_seen + 1'b1;
  end

  // R2: a transaction ends after one or four acknowledged beats
  p_beat_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (acks_seen == 4'd1 || acks_seen == 4'd4));

  // R3: captured word holds without an enabled acknowledge
  p_hold_no_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && ien_hi_o) |=> $stable(word_o));

  // R1 / R4: enables only rise after a request
  p_ien_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ien_hi_o) |-> $past(req_valid_i));

  // R4: enables drop in the done cycle
  p_ien_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ien_hi_o && !ien_lo_o));

  // R5: done follows an enabled acknowledge and lasts one cycle
  p_done_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ack_i && ien_hi_o));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind split_rd_collector split_rd_collector_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .ack_i       (ack_i),
  .ien_hi_o    (ien_hi_o),
  .ien_lo_o    (ien_lo_o),
  .done_o      (done_o),
  .word_o      (word_o)
);

// File: tb/split_rd_collector_tb_top.sv
module split_rd_collector_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         req_valid_i, req_burst_i, ack_i;
  logic [31:0]  data_hi_i, data_lo_i;
  logic [2:0]   lane_sel_i;
  logic         ien_hi_o, ien_lo_o, done_o;
  logic [63:0]  word_o;
  logic [255:0] line_o;
  logic [7:0]   lane_byte_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  split_rd_collector dut_i (.*);

  // behavioural reference
  bit           m_busy, m_done;
  int           m_left, m_idx;
  logic [63:0]  m_word;
  logic [255:0] m_line;
  logic [63:0]  m_beats[$];

  always @(posedge clk_i or negedge rst_ni) begin
    cycles++;
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_left = 0; m_idx = 0;
      m_word = '0; m_line = '0; m_beats.delete();
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (ack_i) begin
          m_word = {data_hi_i, data_lo_i};
          m_beats.push_back(m_word);
          m_line[255-64*m_idx -: 64] = m_word;
          m_idx++;
          m_left--;
          if (m_left == 0) begin m_busy = 0; m_done = 1; m_beats.delete(); end
        end
      end else if (req_valid_i) begin
        m_busy = 1; m_idx = 0;
        m_left = req_burst_i ? 4 : 1;
      end
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R4 ien_hi", 256'(ien_hi_o), 256'(m_busy));
      chk("R4 ien_lo", 256'(ien_lo_o), 256'(m_busy));
      chk("R5 R2 done", 256'(done_o), 256'(m_done));
      chk("R7 R3 word", 256'(word_o), 256'(m_word));
      chk("R8 lane", 256'(lane_byte_o), 256'(m_word[63-8*lane_sel_i -: 8]));
      if (m_done) chk("R6 line", line_o, m_line);
    end
  end

  task automatic cyc(input bit v, input bit b, input bit a);
    @(negedge clk_i);
    #1;
    req_valid_i = v; req_burst_i = b; ack_i = a;
    data_hi_i = $urandom; data_lo_i = $urandom;
    lane_sel_i = 3'($urandom);
  endtask

  initial begin
    rst_ni = 0; req_valid_i = 0; req_burst_i = 0; ack_i = 0;
    data_hi_i = '1; data_lo_i = '1; lane_sel_i = 0;
    #2;
    // R9 reset state
    chk("R9 ien", 256'({ien_hi_o, ien_lo_o}), 256'(0));
    chk("R9 done", 256'(done_o), 256'(0));
    chk("R9 word", 256'(word_o), 256'(0));
    chk("R9 line", line_o, 256'(0));
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1;

    // R3: ack while idle ignored
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 0);
    // R2: single beat with delayed ack
    cyc(1, 0, 1); cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 0);
    // R6: burst with gaps and a request mid-transaction (R1)
    cyc(1, 1, 0); cyc(0, 0, 1); cyc(0, 0, 0); cyc(1, 0, 1); cyc(1, 1, 0);
    cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 0);
    // back-to-back burst: acks every cycle, new request on done cycle
    cyc(1, 1, 0); cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
    cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 0);
    // R8: lane sweep on a fixed beat
    @(negedge clk_i); #1;
    req_valid_i = 1; req_burst_i = 0; ack_i = 0;
    @(negedge clk_i); #1;
    req_valid_i = 0; ack_i = 1;
    data_hi_i = 32'h0011_2233; data_lo_i = 32'h4455_6677;
    @(negedge clk_i); #1; ack_i = 0;
    for (int l = 0; l < 8; l++) begin
      lane_sel_i = 3'(l);
      #1;
      chk("R8 sweep", 256'(lane_byte_o), 256'(8'h00 + 8'(l * 8'h11)));
    end
    // random traffic
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 3) == 0, $urandom % 2, ($urandom % 2) == 0);
    repeat (8) cyc(0, 0, 1);
    cyc(0, 0, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule